// File: doc/BRIEF.md
# Converter Sample Framer and Scrambler

This block turns a stream of 12-bit converter samples into two-octet frames for a serial link. On each clock that carries a valid sample it builds a 16-bit frame: the upper eleven-to-four sample bits become the first octet. The lowest four sample bits and a four-bit tail field form the second octet. The top tail bit can carry the sample's out-of-range flag when the tail mode allows it. The frame is then either passed through as it is or scrambled with a self-synchronizing additive-feedback scrambler, polynomial 1 + x^14 + x^15, unrolled to process all sixteen bits in one clock.

The result leaves through a registered output stage as a high octet and a low octet, transmitted high first, with a valid strobe and a per-octet control-character indicator. A downstream 8b/10b encoder consumes these. The indicator travels alongside the data and is never altered. The tail mode and the scrambler enable are sampled with each frame, so they may change between frames.

Top module: `sample_framer`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs go to zero on that edge and the scrambler history is cleared to all zeros. The first scrambled frame after reset is computed from a zero history, so sample 0x800 with tail zero scrambles to high octet 0x80, low octet 0x03.
- R2: The high output octet carries sample bits 11..4 of the frame (octet bit 7 = sample bit 11) when scrambling is off.
- R3: The low output octet carries sample bits 3..0 in its bits 7..4 when scrambling is off.
- R4: With `cfg_oor_tail_i` = 1, bit 3 of the low octet carries `smp_oor_i` and bits 2..0 are zero. With `cfg_oor_tail_i` = 0, all four tail bits are zero and `smp_oor_i` has no effect.
- R5: With `cfg_scr_en_i` = 0, the frame is output unmodified: {high, low} equals {sample, tail}.
- R6: With `cfg_scr_en_i` = 1, frame bit 15 is the earliest in time. Each output bit equals the input bit XOR the scrambled bits sent 14 and 15 bit-times earlier, and this history continues across consecutive scrambled frames.
- R7: The scrambler history advances only on frames that are both valid and scrambled. Idle cycles and unscrambled frames leave it unchanged, so a later scrambled frame continues from the last scrambled one.
- R8: `oct_valid_o` equals `smp_valid_i` delayed by exactly one clock.
- R9: `oct_ctrl_o` equals the `smp_ctrl_i` of the same frame, delayed by one clock, unmodified by tail mode or scrambling.
- R10: When `smp_valid_i` is low, the octet and control outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid_i | input | 1 | A sample is presented this cycle |
| smp_data_i | input | 12 | Converter sample |
| smp_oor_i | input | 1 | Out-of-range flag for the sample |
| smp_ctrl_i | input | 2 | Control-character indicator, bit 1 for the high octet, bit 0 for the low |
| cfg_oor_tail_i | input | 1 | 1: top tail bit carries the out-of-range flag |
| cfg_scr_en_i | input | 1 | 1: scramble the frame |
| oct_valid_o | output | 1 | Output octets are new this cycle |
| oct_hi_o | output | 8 | First octet of the frame |
| oct_lo_o | output | 8 | Second octet of the frame |
| oct_ctrl_o | output | 2 | Control-character indicator, delayed with the frame |

## Verification
The bench targets the bit-time ordering of the scrambler. If frame bit 0 were treated as earliest, or the taps were off by one, the hand-computed 0x8003 result after reset would fail, and so would every frame of a long random stream. It also interleaves idle cycles and unscrambled frames inside a scrambled stream. A design that advanced or cleared the history on those cycles would diverge on the next scrambled frame. Out-of-range flags are driven with the tail mode both on and off, so a tail that leaks the flag is caught. A reset in mid-stream checks that stale history does not survive.

// File: rtl/sfs_pkg.sv
// Shared types for the sample framer.
// Assumes: configuration is sampled together with each frame.
package sfs_pkg;
    // Per-frame configuration bundle.
    typedef struct packed {
        logic oor_tail;   // top tail bit carries the out-of-range flag
        logic scr_en;     // scramble the frame
    } frame_cfg_t;
endpackage

// File: rtl/frame_packer.sv
// Packs one sample and its tail field into a frame, sample in the upper bits.
// Assumes: SAMPLE_W + TAIL_W equals 2*OCTET_W; purely combinational.
module frame_packer #(
    parameter int SAMPLE_W = 12,
    parameter int OCTET_W  = 8,
    parameter int TAIL_W   = 4,
    localparam int FRAME_W = 2 * OCTET_W
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                oor_i,
    input  logic                oor_tail_i,
    output logic [FRAME_W-1:0]  frame_o
);
    logic [TAIL_W-1:0] tail;

    // Build the tail: only the top bit may carry the flag, the rest stay zero.
    always_comb begin
        tail               = '0;
        tail[TAIL_W-1]     = oor_i & oor_tail_i;
    end

    // Concatenate sample above tail.
    always_comb frame_o = {sample_i, tail};
endmodule

// File: rtl/frame_scrambler.sv
// Parallel self-synchronizing scrambler, polynomial 1 + x^NEAR + x^FAR.
// Frame bit FRAME_W-1 is the earliest in time. The history holds the last
// FAR scrambled bits; bit 0 of it is the most recent.
// Assumes: adv_i is high only for valid frames with scrambling enabled.
module frame_scrambler #(
    parameter int FRAME_W  = 16,
    parameter int TAP_NEAR = 14,
    parameter int TAP_FAR  = 15,
    localparam int HIST_W  = TAP_FAR,
    localparam int EXT_W   = HIST_W + FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv_i,
    input  logic               en_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic [FRAME_W-1:0] frame_o
);
    logic [HIST_W-1:0]  hist_q;
    logic [FRAME_W-1:0] scr;
    logic [EXT_W-1:0]   ext_next;

    // Unroll the serial recurrence, earliest bit first.
    always_comb begin
        logic [EXT_W-1:0] e;
        e = {hist_q, {FRAME_W{1'b0}}};
        for (int i = FRAME_W - 1; i >= 0; i--) begin
            e[i] = frame_i[i] ^ e[i + TAP_NEAR] ^ e[i + TAP_FAR];
        end
        scr = e[FRAME_W-1:0];
    end

    // Select scrambled or raw frame.
    always_comb frame_o = en_i ? scr : frame_i;

    // New history is the most recent HIST_W bits of history followed by output.
    always_comb ext_next = {hist_q, scr};

    // Advance history on scrambled frames only.
    always_ff @(posedge clk) begin
        if (!rst_n)     hist_q <= '0;
        else if (adv_i) hist_q <= ext_next[HIST_W-1:0];
    end

    // History must not move on frames that are idle or unscrambled.
    assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(hist_q));

    // After an advance, the newest history bit is the last output bit sent.
    assert_hist_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> hist_q[0] == $past(frame_o[0]));
endmodule

// File: rtl/sample_framer.sv
// Top: packs a converter sample into two octets, optionally scrambles, and
// registers the frame with valid and control indicator.
// Assumes: one sample per clock at most; configuration may change per frame.
module sample_framer #(
    parameter int SAMPLE_W = 12,
    parameter int OCTET_W  = 8,
    parameter int TAIL_W   = 4,
    parameter int CTRL_W   = 2,
    localparam int FRAME_W = 2 * OCTET_W,
    localparam int NUM_OCT = FRAME_W / OCTET_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    input  logic                smp_oor_i,
    input  logic [CTRL_W-1:0]   smp_ctrl_i,
    input  logic                cfg_oor_tail_i,
    input  logic                cfg_scr_en_i,
    output logic                oct_valid_o,
    output logic [OCTET_W-1:0]  oct_hi_o,
    output logic [OCTET_W-1:0]  oct_lo_o,
    output logic [CTRL_W-1:0]   oct_ctrl_o
);
    import sfs_pkg::*;

    frame_cfg_t          cfg;
    logic [FRAME_W-1:0]  packed_frame;
    logic [FRAME_W-1:0]  line_frame;
    logic                valid_q;
    logic [CTRL_W-1:0]   ctrl_q;
    logic [OCTET_W-1:0]  oct_q [NUM_OCT];

    // Bundle the per-frame configuration.
    always_comb cfg = '{oor_tail: cfg_oor_tail_i, scr_en: cfg_scr_en_i};

    frame_packer #(
        .SAMPLE_W (SAMPLE_W),
        .OCTET_W  (OCTET_W),
        .TAIL_W   (TAIL_W)
    ) u_packer (
        .sample_i   (smp_data_i),
        .oor_i      (smp_oor_i),
        .oor_tail_i (cfg.oor_tail),
        .frame_o    (packed_frame)
    );

    frame_scrambler #(
        .FRAME_W  (FRAME_W),
        .TAP_NEAR (14),
        .TAP_FAR  (15)
    ) u_scrambler (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (smp_valid_i & cfg.scr_en),
        .en_i    (cfg.scr_en),
        .frame_i (packed_frame),
        .frame_o (line_frame)
    );

    // Valid strobe: one clock of delay.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= smp_valid_i;
    end

    // Control indicator: captured with each valid frame.
    always_ff @(posedge clk) begin
        if (!rst_n)           ctrl_q <= '0;
        else if (smp_valid_i) ctrl_q <= smp_ctrl_i;
    end

    // One output register per octet lane; lane 0 is the earliest octet.
    for (genvar g = 0; g < NUM_OCT; g++) begin : g_lane
        localparam int HI = FRAME_W - 1 - g * OCTET_W;
        // Capture this lane's octet on a valid frame.
        always_ff @(posedge clk) begin
            if (!rst_n)           oct_q[g] <= '0;
            else if (smp_valid_i) oct_q[g] <= line_frame[HI -: OCTET_W];
        end
    end

    // Drive the ports from the lane registers.
    always_comb begin
        oct_valid_o = valid_q;
        oct_hi_o    = oct_q[0];
        oct_lo_o    = oct_q[NUM_OCT-1];
        oct_ctrl_o  = ctrl_q;
    end

    assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_i |=> oct_valid_o);
    assert_idle_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_i |=> !oct_valid_o);
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_i |=> ($stable(oct_hi_o) && $stable(oct_lo_o) && $stable(oct_ctrl_o)));
    assert_ctrl_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_i |=> oct_ctrl_o == $past(smp_ctrl_i));
    assert_raw_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && !cfg_scr_en_i) |=> oct_hi_o == $past(smp_data_i[SAMPLE_W-1 -: OCTET_W]));
    assert_tail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && !cfg_scr_en_i && !cfg_oor_tail_i) |=> oct_lo_o[TAIL_W-1:0] == '0);
endmodule

// File: tb/sample_framer_bench.sv
module sample_framer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [11:0] data = '0;
    logic        oor = 1'b0;
    logic [1:0]  ctrl = '0;
    logic        tail_en = 1'b0;
    logic        scr_en = 1'b0;
    logic        o_valid;
    logic [7:0]  o_hi, o_lo;
    logic [1:0]  o_ctrl;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    bit   mq[$];
    logic e_valid;
    logic [7:0] e_hi, e_lo;
    logic [1:0] e_ctrl;

    always #10 clk = ~clk;

    sample_framer u_sample_framer (
        .clk(clk), .rst_n(rst_n), .smp_valid_i(valid), .smp_data_i(data),
        .smp_oor_i(oor), .smp_ctrl_i(ctrl), .cfg_oor_tail_i(tail_en),
        .cfg_scr_en_i(scr_en), .oct_valid_o(o_valid), .oct_hi_o(o_hi),
        .oct_lo_o(o_lo), .oct_ctrl_o(o_ctrl));

    task automatic model_reset();
        mq.delete();
        for (int k = 0; k < 15; k++) mq.push_back(1'b0);
        e_valid = 0; e_hi = 0; e_lo = 0; e_ctrl = 0;
    endtask

    // Behavioural step: serial bit-by-bit scrambling from a history queue.
    task automatic model_step();
        logic [15:0] f;
        bit b;
        if (!rst_n) begin
            model_reset();
            return;
        end
        e_valid = valid;
        if (valid) begin
            f = {data, (tail_en && oor), 3'b000};
            if (scr_en) begin
                for (int i = 15; i >= 0; i--) begin
                    b = f[i] ^ mq[mq.size()-14] ^ mq[mq.size()-15];
                    f[i] = b;
                    mq.push_back(b);
                    void'(mq.pop_front());
                end
            end
            e_hi = f[15:8]; e_lo = f[7:0]; e_ctrl = ctrl;
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Apply inputs, clock once, compare all outputs against the model.
    task automatic cyc(string tag, bit v, logic [11:0] d, bit o, logic [1:0] c, bit t, bit s);
        valid = v; data = d; oor = o; ctrl = c; tail_en = t; scr_en = s;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R8", {31'b0, o_valid}, {31'b0, e_valid}, "valid");
        check(tag, {16'b0, o_hi, o_lo}, {16'b0, e_hi, e_lo}, "octets");
        check("R9", {30'b0, o_ctrl}, {30'b0, e_ctrl}, "ctrl");
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", {20'b0, o_valid, o_hi, o_lo, o_ctrl, 1'b0}, 32'b0, "reset outputs");
        rst_n = 1'b1;
        // R2 R3 R5: raw packing
        cyc("R2", 1, 12'hA5C, 0, 2'b00, 0, 0);
        cyc("R3", 1, 12'hFFF, 0, 2'b01, 0, 0);
        cyc("R5", 1, 12'h000, 0, 2'b10, 0, 0);
        check("R2", {24'b0, o_hi}, 32'h00, "hi zero");
        // R4: flag ignored with tail mode off, carried with it on
        cyc("R4", 1, 12'h123, 1, 2'b00, 0, 0);
        check("R4", {24'b0, o_lo}, 32'h30, "tail off");
        cyc("R4", 1, 12'h123, 1, 2'b11, 1, 0);
        check("R4", {24'b0, o_lo}, 32'h38, "tail on");
        cyc("R4", 1, 12'h456, 0, 2'b00, 1, 0);
        // R10 R8: idle cycles hold
        cyc("R10", 0, 12'hBAD, 1, 2'b11, 1, 0);
        cyc("R10", 0, 12'h777, 0, 2'b01, 0, 1);
        // R1 R6: reset then known first scrambled frame
        rst_n = 0;
        cyc("R1", 1, 12'h3C3, 1, 2'b11, 1, 1);
        rst_n = 1;
        cyc("R6", 1, 12'h800, 0, 2'b00, 0, 1);
        check("R1", {16'b0, o_hi, o_lo}, 32'h8003, "first scrambled frame");
        // R6: long scrambled stream
        for (int n = 0; n < 60; n++)
            cyc("R6", 1, 12'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1);
        // R7: idle and raw frames interleaved in a scrambled stream
        for (int n = 0; n < 80; n++) begin
            automatic int r = $urandom_range(0, 3);
            cyc("R7", r != 0, 12'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), r != 1);
        end
        // R1: mid-stream reset clears history
        rst_n = 0;
        cyc("R1", 1, 12'h5A5, 0, 2'b00, 0, 1);
        rst_n = 1;
        cyc("R1", 1, 12'h800, 0, 2'b00, 0, 1);
        check("R1", {16'b0, o_hi, o_lo}, 32'h8003, "history cleared");
        cyc("R6", 1, 12'h000, 0, 2'b00, 0, 1);
        cyc("R8", 0, 12'h000, 0, 2'b00, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule